// File: doc/BRIEF.md
# Buffered Serial Transmitter with Selectable Interrupt Conditions

This block serialises bytes onto an asynchronous serial line. A host pushes bytes into a four-entry queue. A shift stage takes them one at a time and sends each as a frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. There is no parity. Bit timing comes from an external strobe that is one clock wide and marks each bit period. The line level changes only in the cycle after that strobe.

The host can also queue a line break. The next frame is then a start bit, twelve more low bits and a stop bit. The break request flag clears itself once that frame ends. An output polarity control inverts the whole line, idle level included. One of three conditions can be chosen to raise a single-cycle interrupt pulse: each move from queue to shifter, the move that drains the queue, or the end of all pending work. The fourth setting produces no pulse. Dropping the enable abandons the current frame, discards the queue and any break request, and returns the line to idle at once.

Top module: `uart_tx_buffered`

## Requirements
- R1: After reset, the line is at its idle level (1 when `inv_pol`=0), `buf_full`=0, `shift_empty`=1, `brk_pending`=0 and `irq`=0.
- R2: A data frame is, in line order, one 0 start bit, the 8 data bits LSB first, and one 1 stop bit. Each bit lasts from one `bit_tick` to the next. The line changes only in the cycle after a `bit_tick`, or on disable.
- R3: The queue holds 4 bytes. `buf_full` is 1 exactly while 4 bytes wait. A write while `buf_full`=1 is discarded and never sent.
- R4: `shift_empty` is 1 only when the shifter is idle, the queue is empty and no break is pending. Otherwise it is 0, and it is never 1 while `buf_full` is 1.
- R5: With `irq_mode`=2'b00, `irq` pulses once for every byte moved from the queue into the shifter.
- R6: With `irq_mode`=2'b10, `irq` pulses only when a byte moves into the shifter and that move leaves the queue empty.
- R7: With `irq_mode`=2'b01, `irq` pulses when a frame ends and no further byte or break is waiting.
- R8: With `irq_mode`=2'b11, `irq` stays 0.
- R9: A `brk_req` pulse while enabled sets `brk_pending`. The next frame is a 0 start bit, twelve 0 bits and a 1 stop bit, and it goes out ahead of queued data. `brk_pending` returns to 0 when that frame ends.
- R10: With `tx_en`=0, the line is idle one cycle later, the queue is empty, any break request is cleared, and writes and break requests are ignored.
- R11: With `inv_pol`=1, the line idles at 0 and every frame bit is inverted.
- R12: When data waits at the end of a stop bit, the next start bit begins on that same tick, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and flushes |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to queue |
| irq_mode | input | 2 | Interrupt condition select |
| brk_req | input | 1 | Pulse requesting a break frame |
| inv_pol | input | 1 | 1 inverts the line and its idle level |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| tx_line | output | 1 | Serial output line |
| buf_full | output | 1 | Queue cannot accept another byte |
| shift_empty | output | 1 | No frame in progress or waiting |
| brk_pending | output | 1 | Break requested and not yet finished |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Errors in the queue pointers or the count show up as bytes that are lost, repeated or reordered on the line. They also show up as `buf_full` or `shift_empty` having the wrong value in the cycle after a write, before any tick arrives. An off-by-one in the bit counter lengthens or shortens a frame, which the tick-by-tick line record shows within the first frame. An error in the interrupt selection shows up as a wrong pulse count once the queue has drained. Abort errors show up in the cycle after `tx_en` falls, as a non-idle line or stale status, or later as a frame that should never have been sent.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [1:0] {
        IRQ_ON_XFER  = 2'b00,
        IRQ_ON_DONE  = 2'b01,
        IRQ_ON_DRAIN = 2'b10,
        IRQ_NONE     = 2'b11
    } irq_mode_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    assign full      = (st_q.cnt == CNT_W'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign head_data = st_q.mem[st_q.rd_ptr];
    assign count     = st_q.cnt;

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wr_ptr] = push_data;
            st_d.wr_ptr = (st_q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr_ptr + PTR_W'(1);
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd_ptr + PTR_W'(1);
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
    parameter int DATA_W    = 8,
    parameter int BRK_ZEROS = 12,
    localparam int DATA_LEN = DATA_W + 2,
    localparam int BRK_LEN  = BRK_ZEROS + 2,
    localparam int FRAME_W  = utx_pkg::max_int(DATA_LEN, BRK_LEN),
    localparam int CNT_W    = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              have_data,
    input  logic [DATA_W-1:0] data,
    input  logic              brk_want,
    output logic              pop,
    output logic              brk_done,
    output logic              finish_idle,
    output logic              busy,
    output logic              line_raw
);

    typedef struct packed {
        logic               busy;
        logic               is_brk;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   left;
        logic               line;
    } shf_st_t;

    localparam shf_st_t IDLE_ST = '{busy: 1'b0, is_brk: 1'b0, shreg: '0, left: '0, line: 1'b1};

    shf_st_t            st_d, st_q;
    logic [FRAME_W-1:0] frm;
    logic               start_brk;

    assign busy     = st_q.busy;
    assign line_raw = st_q.line;

    always_comb begin
        st_d        = st_q;
        pop         = 1'b0;
        brk_done    = 1'b0;
        finish_idle = 1'b0;
        frm         = '0;
        start_brk   = brk_want && !(st_q.busy && st_q.is_brk);
        if (!enable) begin
            st_d = IDLE_ST;
        end else if (tick) begin
            if (st_q.busy && (st_q.left != '0)) begin
                st_d.line  = st_q.shreg[0];
                st_d.shreg = st_q.shreg >> 1;
                st_d.left  = st_q.left - CNT_W'(1);
            end else begin
                st_d = IDLE_ST;
                if (st_q.busy) begin
                    brk_done = st_q.is_brk;
                end
                if (start_brk) begin
                    frm[BRK_LEN-1] = 1'b1;
                    st_d.busy      = 1'b1;
                    st_d.is_brk    = 1'b1;
                    st_d.line      = 1'b0;
                    st_d.shreg     = frm >> 1;
                    st_d.left      = CNT_W'(BRK_LEN - 1);
                end else if (have_data) begin
                    pop                 = 1'b1;
                    frm[DATA_LEN-1]     = 1'b1;
                    frm[DATA_W:1]       = data;
                    st_d.busy           = 1'b1;
                    st_d.line           = 1'b0;
                    st_d.shreg          = frm >> 1;
                    st_d.left           = CNT_W'(DATA_LEN - 1);
                end else if (st_q.busy) begin
                    finish_idle = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IDLE_ST;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/utx_irq.sv
module utx_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] mode,
    input  logic       xfer,
    input  logic       drained,
    input  logic       finished,
    output logic       irq
);
    import utx_pkg::*;

    typedef struct packed {
        logic pulse;
    } irq_st_t;

    irq_st_t   st_d, st_q;
    irq_mode_e sel;

    assign irq = st_q.pulse;

    always_comb begin
        sel        = irq_mode_e'(mode);
        st_d.pulse = 1'b0;
        unique case (sel)
            IRQ_ON_XFER:  st_d.pulse = xfer;
            IRQ_ON_DRAIN: st_d.pulse = drained;
            IRQ_ON_DONE:  st_d.pulse = finished;
            IRQ_NONE:     st_d.pulse = 1'b0;
            default:      st_d.pulse = 1'b0;
        endcase
        if (!enable) begin
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 4,
    parameter int BRK_ZEROS = 12,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        irq_mode,
    input  logic              brk_req,
    input  logic              inv_pol,
    input  logic              bit_tick,
    output logic              tx_line,
    output logic              buf_full,
    output logic              shift_empty,
    output logic              brk_pending,
    output logic              irq
);

    typedef struct packed {
        logic brk;
    } ctl_st_t;

    ctl_st_t            ctl_d, ctl_q;
    logic               push, pop, fifo_full, fifo_empty;
    logic [DATA_W-1:0]  head_data;
    logic [CNT_W-1:0]   fifo_cnt;
    logic               brk_done, finish_idle, sh_busy, line_raw, drained;

    assign push = wr_valid && tx_en;

    utx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!tx_en),
        .push      (push),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head_data),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    utx_shifter #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (tx_en),
        .tick        (bit_tick),
        .have_data   (!fifo_empty),
        .data        (head_data),
        .brk_want    (ctl_q.brk),
        .pop         (pop),
        .brk_done    (brk_done),
        .finish_idle (finish_idle),
        .busy        (sh_busy),
        .line_raw    (line_raw)
    );

    assign drained = pop && (fifo_cnt == CNT_W'(1)) && !push;

    utx_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tx_en),
        .mode     (irq_mode),
        .xfer     (pop),
        .drained  (drained),
        .finished (finish_idle),
        .irq      (irq)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (brk_done) begin
            ctl_d.brk = 1'b0;
        end
        if (brk_req) begin
            ctl_d.brk = 1'b1;
        end
        if (!tx_en) begin
            ctl_d.brk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_line     = line_raw ^ inv_pol;
    assign buf_full    = fifo_full;
    assign brk_pending = ctl_q.brk;
    assign shift_empty = !sh_busy && fifo_empty && !ctl_q.brk;

endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       bit_tick,
    input logic       inv_pol,
    input logic [1:0] irq_mode,
    input logic       tx_line,
    input logic       buf_full,
    input logic       shift_empty,
    input logic       irq
);

    // R2: without a tick the line holds its level, unless polarity is switched
    a_r2_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && tx_en) |=> ($stable(tx_line) || !$stable(inv_pol)));

    // R3: a full queue stays full while nothing can leave it
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && tx_en && !bit_tick) |=> buf_full);

    // R4: all-empty status excludes a full queue
    a_r4_empty_excl_full: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> !buf_full);

    // R8: reserved interrupt setting stays silent
    a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'b11) |=> !irq);

    // R10: disabling idles the line on the next cycle
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (tx_line == !inv_pol));

endmodule

bind uart_tx_buffered utx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .bit_tick    (bit_tick),
    .inv_pol     (inv_pol),
    .irq_mode    (irq_mode),
    .tx_line     (tx_line),
    .buf_full    (buf_full),
    .shift_empty (shift_empty),
    .irq         (irq)
);

// File: tb/uart_tx_buffered_bench.sv
module uart_tx_buffered_bench;

    localparam int DIV   = 4;
    localparam int LOG_N = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] irq_mode = 2'b00;
    logic       brk_req = 1'b0;
    logic       inv_pol = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_line, buf_full, shift_empty, brk_pending, irq;

    logic       line_log [LOG_N];
    int         log_n = 0;
    int         irq_seen = 0;
    bit         tick_on = 1'b0;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    uart_tx_buffered u_uart_tx_buffered (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .irq_mode    (irq_mode),
        .brk_req     (brk_req),
        .inv_pol     (inv_pol),
        .bit_tick    (bit_tick),
        .tx_line     (tx_line),
        .buf_full    (buf_full),
        .shift_empty (shift_empty),
        .brk_pending (brk_pending),
        .irq         (irq)
    );

    initial forever #10 clk = ~clk;

    // tick generator and line recorder: one sample per bit period, taken before its ending tick
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (irq) irq_seen++;
            if (tick_on) begin
                div = (div == DIV - 1) ? 0 : div + 1;
                bit_tick = (div == DIV - 1);
                if (bit_tick && log_n < LOG_N) begin
                    line_log[log_n] = tx_line;
                    log_n++;
                end
            end else begin
                bit_tick = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int find_start(input int from);
        for (int i = from; i < log_n; i++) begin
            if ((line_log[i] ^ inv_pol) == 1'b0) return i;
        end
        return -1;
    endfunction

    function automatic int grab(input int from, input int len);
        int v = 0;
        for (int i = 0; i < len; i++) begin
            if (from + i < log_n && (line_log[from + i] ^ inv_pol)) v |= (1 << i);
        end
        return v;
    endfunction

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_brk();
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (!shift_empty && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) check({req, " idle timeout"}, 0, 1);
        repeat (3 * DIV) @(negedge clk);
    endtask

    task automatic fresh_log();
        @(negedge clk);
        log_n = 0;
        irq_seen = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 line idle", tx_line, 1);
        check("R1 buf_full", buf_full, 0);
        check("R1 shift_empty", shift_empty, 1);
        check("R1 brk_pending", brk_pending, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_single();
        int s;
        irq_mode = 2'b00;
        tick_on = 1'b1;
        fresh_log();
        write_byte(8'hA5);
        check("R4 busy after write", shift_empty, 0);
        wait_idle("R2");
        s = find_start(0);
        check("R2 start found", (s > 0) ? 1 : 0, 1);
        check("R2 idle before start", grab(0, s), (1 << s) - 1);
        check("R2 frame bits", grab(s, 10), 10'h200 | (8'hA5 << 1));
        check("R2 idle after stop", find_start(s + 10), -1);
        check("R5 single xfer irq", irq_seen, 1);
    endtask

    task automatic t_fill();
        int s;
        irq_mode = 2'b01;
        tick_on = 1'b0;
        fresh_log();
        write_byte(8'h11);
        write_byte(8'h22);
        write_byte(8'h33);
        check("R3 not full at 3", buf_full, 0);
        write_byte(8'h44);
        check("R3 full at 4", buf_full, 1);
        check("R4 not empty when queued", shift_empty, 0);
        write_byte(8'h55);
        check("R3 full after dropped write", buf_full, 1);
        tick_on = 1'b1;
        wait_idle("R3");
        s = find_start(0);
        check("R12 frame 1", grab(s, 10), 10'h200 | (8'h11 << 1));
        check("R12 frame 2 back to back", grab(s + 10, 10), 10'h200 | (8'h22 << 1));
        check("R12 frame 3 back to back", grab(s + 20, 10), 10'h200 | (8'h33 << 1));
        check("R12 frame 4 back to back", grab(s + 30, 10), 10'h200 | (8'h44 << 1));
        check("R3 dropped byte never sent", find_start(s + 40), -1);
        check("R7 one irq at end of work", irq_seen, 1);
    endtask

    task automatic run_irq(input logic [1:0] mode, input int exp, input string req);
        irq_mode = mode;
        tick_on = 1'b0;
        fresh_log();
        write_byte(8'h01);
        write_byte(8'h02);
        write_byte(8'h03);
        tick_on = 1'b1;
        wait_idle(req);
        check(req, irq_seen, exp);
    endtask

    task automatic t_break();
        int s;
        irq_mode = 2'b00;
        tick_on = 1'b0;
        fresh_log();
        pulse_brk();
        check("R9 brk_pending set", brk_pending, 1);
        check("R4 not empty with break pending", shift_empty, 0);
        write_byte(8'h3C);
        tick_on = 1'b1;
        wait_idle("R9");
        s = find_start(0);
        check("R9 break frame first", grab(s, 14), 14'h2000);
        check("R9 data after break", grab(s + 14, 10), 10'h200 | (8'h3C << 1));
        check("R9 brk_pending cleared", brk_pending, 0);
        check("R5 break is not a transfer", irq_seen, 1);
    endtask

    task automatic t_abort();
        int mark;
        irq_mode = 2'b00;
        tick_on = 1'b1;
        fresh_log();
        write_byte(8'h00);
        write_byte(8'h0F);
        write_byte(8'hF0);
        repeat (6 * DIV) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check("R10 line idle after abort", tx_line, 1);
        check("R10 queue flushed", shift_empty, 1);
        check("R10 not full", buf_full, 0);
        write_byte(8'h77);
        pulse_brk();
        check("R10 break ignored while off", brk_pending, 0);
        @(negedge clk);
        tx_en = 1'b1;
        mark = log_n;
        repeat (30 * DIV) @(negedge clk);
        check("R10 nothing sent after re-enable", find_start(mark), -1);
        check("R10 still empty", shift_empty, 1);
    endtask

    task automatic t_invert();
        int s;
        irq_mode = 2'b00;
        inv_pol = 1'b1;
        @(negedge clk);
        check("R11 idle low", tx_line, 0);
        fresh_log();
        write_byte(8'h96);
        wait_idle("R11");
        s = find_start(0);
        check("R11 raw start bit high", line_log[s], 1);
        check("R11 inverted frame", grab(s, 10), 10'h200 | (8'h96 << 1));
        inv_pol = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        tx_en = 1'b1;
        t_single();
        t_fill();
        run_irq(2'b00, 3, "R5 every transfer");
        run_irq(2'b10, 1, "R6 drain transfer only");
        run_irq(2'b01, 1, "R7 end of work");
        run_irq(2'b11, 0, "R8 reserved silent");
        t_break();
        t_abort();
        t_invert();
        finish_run();
    end

endmodule